// File: doc/BRIEF.md
# Strobe Activity Watchdog

This block watches a software-driven strobe line for signs of life and pulls an active-low watchdog flag when the strobe has stayed quiet for longer than a programmed number of clock cycles. The strobe arrives asynchronously. It passes through a synchronizer and a stability filter, so that only level changes held for a minimum number of cycles count as activity. Each qualified change clears the timeout counter. When the counter reaches the limit, it stops there and the flag goes low. The next qualified change raises the flag again and starts a fresh count.

The timer runs only under four conditions: the system reset input is released, the manual reset is released, the supply is good, and the strobe is actually driven. A separate flag marks the undriven strobe case. While the strobe is undriven, the timer is held at zero and the flag stays high. A supply fault overrides everything and forces the flag low, so with an undriven strobe the output acts as a plain low-supply indicator. A low manual reset forces the flag high. The output is registered and leaves the block one clock after its cause.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst` is high, and until the first enabling conditions are sampled, `wdog_n` is 0.
- R2: A level change on `strobe_raw` counts as activity only if the new level is held for at least FILT_CYCLES consecutive clock cycles. A change that is held for FILT_CYCLES-1 cycles and then undone has no effect on `wdog_n`.
- R3: The timer is enabled in the cycle after all of its enabling conditions become true. It starts from zero at that point. If there is no activity, `wdog_n` is still 1 after TIMEOUT_CYC clock edges and is 0 after TIMEOUT_CYC+1 edges. The counter then saturates, so `wdog_n` stays 0 for as long as no activity arrives.
- R4: Each qualified activity restarts the count from zero. Activity repeated at intervals shorter than TIMEOUT_CYC keeps `wdog_n` at 1.
- R5: After a timeout, a qualified strobe change drives `wdog_n` back to 1. This happens FILT_CYCLES+4 clock edges after the change is applied at the input, and not one edge earlier.
- R6: While `strobe_undriven` is 1, the timer is held at zero and `wdog_n` is 1 from the next edge. After the flag returns to 0, a full TIMEOUT_CYC+1 edges pass before `wdog_n` falls.
- R7: While `sys_reset_n` is 0, the timer is held at zero and `wdog_n` stays 1 (given the supply is good), however long the hold lasts.
- R8: When `supply_ok` is 0, `wdog_n` is 0 from the next edge. This holds whatever the timer state and whatever the other inputs are.
- R9: When `manual_reset_n` is 0 and `supply_ok` is 1, `wdog_n` is 1 from the next edge and the timer is held at zero.
- R10: At power-up, `wdog_n` rises one edge after `supply_ok` rises, even while `sys_reset_n` is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| strobe_raw | input | 1 | Asynchronous watchdog strobe |
| strobe_undriven | input | 1 | 1 when the strobe line is not driven (synchronous) |
| supply_ok | input | 1 | 1 when the supply is within range |
| sys_reset_n | input | 1 | System reset level, 0 = reset asserted |
| manual_reset_n | input | 1 | Manual reset, 0 = asserted |
| wdog_n | output | 1 | Registered active-low watchdog flag |

## Verification
Suppose the timeout counter is corrupted, for example by wrapping past the limit or by failing to clear on a qualified edge. The first place this shows is the exact edge on which `wdog_n` falls: it goes low early, late, or briefly rises again within one timeout period. A filter that is too permissive or too strict shifts the recovery edge after a strobe change by one or more cycles, or lets a short glitch raise the flag. The bench samples those exact edges. A wrong priority between supply fault, manual reset and timer appears at `wdog_n` one cycle after the forcing input changes.

// File: rtl/swd_pkg.sv
package swd_pkg;
  // Source that decides the next value of the watchdog flag
  typedef enum logic [1:0] {
    SEL_FORCE_LOW  = 2'd0,
    SEL_FORCE_HIGH = 2'd1,
    SEL_TIMER      = 2'd2
  } out_sel_e;

  function automatic int width_for(input int max_value);
    return (max_value < 2) ? 1 : $clog2(max_value + 1);
  endfunction
endpackage

// File: rtl/swd_sync.sv
module swd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/swd_filter.sv
module swd_filter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic activity
);
  import swd_pkg::*;
  localparam int CW = width_for(FILT_CYCLES);

  logic          settled;
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      settled  <= 1'b0;
      run_len  <= '0;
      activity <= 1'b0;
    end else begin
      activity <= 1'b0;
      if (level_in != settled) begin
        if (run_len == CW'(FILT_CYCLES - 1)) begin
          settled  <= level_in;
          run_len  <= '0;
          activity <= 1'b1;
        end else begin
          run_len <= run_len + CW'(1);
        end
      end else begin
        run_len <= '0;
      end
    end
  end

  // R2: an activity pulse always comes with a new accepted level
  p_act_changes_level_r2: assert property (@(posedge clk) disable iff (rst)
    activity |-> (settled != $past(settled)));

  // R2: the run length never exceeds the filter window
  p_run_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    run_len < CW'(FILT_CYCLES));
endmodule

// File: rtl/swd_timer.sv
module swd_timer #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic kick,
  output logic expired
);
  import swd_pkg::*;
  localparam int TW = width_for(TIMEOUT_CYC);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);

  logic [TW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || !enable)    count <= '0;
    else if (kick)         count <= '0;
    else if (count != LIMIT) count <= count + TW'(1);
  end

  assign expired = (count == LIMIT);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count <= LIMIT);

  p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
    (enable && !kick && count == LIMIT) |=> count == LIMIT);

  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && kick) |=> count == '0);

  p_held_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> count == '0);
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_raw,
  input  logic strobe_undriven,
  input  logic supply_ok,
  input  logic sys_reset_n,
  input  logic manual_reset_n,
  output logic wdog_n
);
  import swd_pkg::*;

  logic strobe_s;
  logic activity;
  logic timer_en;
  logic expired;
  out_sel_e sel;

  swd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(strobe_raw), .q_sync(strobe_s)
  );

  swd_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
    .clk(clk), .rst(rst), .level_in(strobe_s), .activity(activity)
  );

  assign timer_en = supply_ok && sys_reset_n && manual_reset_n && !strobe_undriven;

  swd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .enable(timer_en), .kick(activity), .expired(expired)
  );

  // Priority: supply fault, then manual reset / undriven strobe, then timer
  always_comb begin
    if (!supply_ok)                            sel = SEL_FORCE_LOW;
    else if (!manual_reset_n || strobe_undriven) sel = SEL_FORCE_HIGH;
    else                                       sel = SEL_TIMER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdog_n <= 1'b0;
    end else begin
      unique case (sel)
        SEL_FORCE_LOW:  wdog_n <= 1'b0;
        SEL_FORCE_HIGH: wdog_n <= 1'b1;
        default:        wdog_n <= !expired;
      endcase
    end
  end

  p_supply_low_r8: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !wdog_n);

  p_manual_high_r9: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && !manual_reset_n) |=> wdog_n);

  p_undriven_high_r6: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && strobe_undriven) |=> wdog_n);

  p_sysreset_high_r7: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && !sys_reset_n && $past(!sys_reset_n)) |=> wdog_n);
endmodule

// File: tb/strobe_watchdog_tb_top.sv
module strobe_watchdog_tb_top;
  localparam int M = 4;
  localparam int T = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe_raw = 1'b0;
  logic strobe_undriven = 1'b0;
  logic supply_ok = 1'b0;
  logic sys_reset_n = 1'b0;
  logic manual_reset_n = 1'b1;
  logic wdog_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strobe_watchdog #(.SYNC_STAGES(2), .FILT_CYCLES(M), .TIMEOUT_CYC(T)) dut_i (
    .clk(clk), .rst(rst), .strobe_raw(strobe_raw), .strobe_undriven(strobe_undriven),
    .supply_ok(supply_ok), .sys_reset_n(sys_reset_n), .manual_reset_n(manual_reset_n),
    .wdog_n(wdog_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (wdog_n !== exp) begin
      errors++;
      $display("FAIL %s: wdog_n actual=%b expected=%b at %0t", req, wdog_n, exp, $time);
    end
  endtask

  task automatic t_reset();
    step(3);
    check("R1 during reset", 1'b0);
    rst = 1'b0;
    step(2);
    check("R1 after reset, supply not good", 1'b0);
  endtask

  task automatic t_powerup();
    supply_ok = 1'b1;
    step(1);
    check("R10 high one edge after supply good", 1'b1);
    step(3 * T);
    check("R7 timer held during system reset", 1'b1);
  endtask

  task automatic t_timeout();
    sys_reset_n = 1'b1;
    step(T);
    check("R3 still high at limit", 1'b1);
    step(1);
    check("R3 low one edge later", 1'b0);
    step(200);
    check("R3 saturated, no wrap", 1'b0);
  endtask

  task automatic t_glitch_and_recover();
    strobe_raw = 1'b1;
    step(M - 1);
    strobe_raw = 1'b0;
    step(40);
    check("R2 short pulse ignored", 1'b0);
    strobe_raw = 1'b1;
    step(M + 3);
    check("R5 not yet recovered", 1'b0);
    step(1);
    check("R5 recovered after qualified change", 1'b1);
  endtask

  task automatic t_kick();
    for (int i = 0; i < 10; i++) begin
      strobe_raw = ~strobe_raw;
      step(20);
      check("R4 periodic activity keeps flag high", 1'b1);
    end
    step(T + 20);
    check("R4 expiry after activity stops", 1'b0);
  endtask

  task automatic t_undriven();
    strobe_undriven = 1'b1;
    step(1);
    check("R6 undriven forces high", 1'b1);
    step(3 * T);
    check("R6 timer held while undriven", 1'b1);
    strobe_undriven = 1'b0;
    step(T);
    check("R6 full count after release", 1'b1);
    step(1);
    check("R6 timeout after release", 1'b0);
  endtask

  task automatic t_supply();
    strobe_raw = ~strobe_raw;
    step(M + 4);
    check("R5 recovered before supply test", 1'b1);
    supply_ok = 1'b0;
    step(1);
    check("R8 supply fault forces low", 1'b0);
    strobe_undriven = 1'b1;
    step(2);
    check("R8 supply fault overrides undriven", 1'b0);
    supply_ok = 1'b1;
    step(1);
    check("R8 low-supply indicator releases", 1'b1);
    strobe_undriven = 1'b0;
    step(T);
    check("R8 timer restarted after supply returns", 1'b1);
    step(1);
    check("R8 timeout after supply returns", 1'b0);
  endtask

  task automatic t_manual();
    manual_reset_n = 1'b0;
    step(1);
    check("R9 manual reset forces high", 1'b1);
    step(2 * T);
    check("R9 timer held during manual reset", 1'b1);
    manual_reset_n = 1'b1;
    step(T);
    check("R9 full count after release", 1'b1);
    step(1);
    check("R9 timeout after release", 1'b0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_powerup();
    t_timeout();
    t_glitch_and_recover();
    t_kick();
    t_undriven();
    t_supply();
    t_manual();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule